// File: doc/BRIEF.md
# ADC Result Formatter with Overrun Detection

This block sits between an abstracted analog converter and the bus-facing data registers of a converter subsystem. Each finished conversion arrives as a raw 12-bit code with a valid strobe, a tag saying whether it belongs to the regular or the injected group, and a rank that picks one of four injected slots. The block cuts the code down to the selected resolution. For injected results whose slot has its offset turned on, it subtracts that slot's offset as a two's-complement value. It then places the value right or left aligned in a 16-bit field and writes it to the matching data register.

All regular conversions share one data register. An unread bit tracks whether software or a DMA engine has taken the current value. A new regular result that arrives while the bit is still set raises an overrun flag. When DMA is on, an overrun stops DMA requests and aborts the running sequence: further regular results are dropped until software clears the flag. The block also reports how many converter clock cycles one conversion takes at the current resolution, so that a sequencer can use that figure.

Top module: `adc_result_formatter`

## Requirements
- R1: After a synchronous active-low reset, the regular data, all four injected slots, the unread bit, the overrun flag, the DMA request and the abort output are all zero.
- R2: `cfg_res` selects the resolution: 0 gives 12 bits, 1 gives 10, 2 gives 8 and 3 gives 6. The reduced value is the raw code shifted right by twice `cfg_res`, which drops the low bits. `conv_cycles` equals the resolution plus 3.
- R3: With `cfg_left`=0 and no offset in use, the reduced value sits in bits [res-1:0] and every bit above it is zero.
- R4: With `cfg_left`=1 and no offset in use, the reduced value is shifted left by 16-res, so its MSB lands on bit 15 and the low bits are zero.
- R5: For an injected result whose slot enable `cfg_ofs_en[rank]` is 1, the block computes the reduced value minus the low res bits of that slot's offset `cfg_ofs[rank*12 +: 12]`, as a two's-complement number. Right aligned, this value is sign-extended to 16 bits. Left aligned, it is shifted left by 15-res, so the sign bit lands on bit 15.
- R6: Offsets and offset enables have no effect on regular results.
- R7: An injected result with rank k (0..3) is written to slot k, bits [16k+15:16k] of `inj_data`, one clock after `cv_valid`. The other slots keep their values.
- R8: A regular result is written to `reg_data` one clock after `cv_valid`, and `reg_unread` is set. A `rd_regular` pulse with no regular result in the same cycle clears `reg_unread` on the next clock.
- R9: A regular result that arrives while `reg_unread` is 1 and `rd_regular` is 0 sets `ovr_flag`. A read in the same cycle as a new result does not count as an overrun, and `reg_unread` stays 1.
- R10: With `cfg_dma_en`=0, an overrunning result overwrites `reg_data`. With `cfg_dma_en`=1, the overrunning result is dropped, and while `ovr_flag` is set every regular result is ignored and `seq_abort` is 1.
- R11: `ovr_clear` clears `ovr_flag` on the next clock. If an overrun occurs in the same cycle, the set wins.
- R12: `dma_req` is 1 exactly when `cfg_dma_en` is 1, `reg_unread` is 1 and `ovr_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cv_valid | input | 1 | A conversion result is present this cycle |
| cv_code | input | 12 | Raw conversion code, MSB-justified at full resolution |
| cv_inj | input | 1 | 1 for the injected group, 0 for regular |
| cv_rank | input | 2 | Injected slot index |
| cfg_res | input | 2 | Resolution select (0:12, 1:10, 2:8, 3:6 bits) |
| cfg_left | input | 1 | 1 for left alignment, 0 for right |
| cfg_dma_en | input | 1 | DMA mode enable |
| cfg_ofs_en | input | 4 | Per-slot offset enable |
| cfg_ofs | input | 48 | Four 12-bit slot offsets, slot k at [12k+11:12k] |
| rd_regular | input | 1 | The regular data register is read this cycle |
| ovr_clear | input | 1 | Clear the overrun flag |
| conv_cycles | output | 4 | Converter cycles per conversion at the current resolution |
| reg_data | output | 16 | Regular data register |
| reg_unread | output | 1 | The regular data has not been read yet |
| inj_data | output | 64 | Four 16-bit injected slots, slot k at [16k+15:16k] |
| ovr_flag | output | 1 | Overrun flag |
| dma_req | output | 1 | DMA request for the regular data |
| seq_abort | output | 1 | The regular sequence is aborted by an overrun in DMA mode |

## Verification
Two pairs of events can fall in the same cycle. A read of the regular register can meet a new regular result, and an overrun can meet a software clear. Directed steps put `rd_regular` and `cv_valid` in one cycle and expect no overrun and a set unread bit. Other steps put `ovr_clear` in the same cycle as an overrunning write and expect the flag to stay set. A random phase then drives reads, clears, results and configuration independently on every cycle, so that these collisions also occur in every DMA and alignment mode. A behavioural reference model judges every cycle by comparing all outputs.

// File: rtl/adcfmt_pkg.sv
// Package: shared helpers for the conversion result formatter.
// Assumes the resolution select steps the width down by two bits per code.
package adcfmt_pkg;
    localparam int RES_STEP = 2;

    // Number of significant bits kept for a given resolution select.
    function automatic int res_bits(input int code_w, input logic [1:0] sel);
        return code_w - RES_STEP * int'(sel);
    endfunction
endpackage

// File: rtl/adcfmt_shape.sv
// Module: adcfmt_shape
// Combinational path that turns a raw code into a 16-bit field. It reduces
// the code to the selected resolution, can subtract an offset as a signed
// value, and aligns the result left or right.
// Assumes DATA_W > CODE_W, so a signed difference fits with its sign bit.
module adcfmt_shape #(
    parameter int CODE_W = 12,
    parameter int DATA_W = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        res_sel,
    input  logic              left,
    input  logic              signed_en,
    input  logic [CODE_W-1:0] ofs,
    output logic [DATA_W-1:0] data
);
    import adcfmt_pkg::*;

    int                 keep;
    logic [CODE_W-1:0]  reduced;
    logic [CODE_W-1:0]  mask;
    logic [CODE_W:0]    diff;
    logic [DATA_W-1:0]  sext;
    logic [DATA_W-1:0]  zext;

    // Reduce, optionally subtract the offset, then align into the field.
    always_comb begin
        keep    = res_bits(CODE_W, res_sel);
        reduced = code >> (RES_STEP * int'(res_sel));
        mask    = ~({CODE_W{1'b1}} << keep);
        diff    = {1'b0, reduced} - {1'b0, ofs & mask};
        sext    = {{(DATA_W-CODE_W-1){diff[CODE_W]}}, diff};
        zext    = {{(DATA_W-CODE_W){1'b0}}, reduced};
        if (signed_en)
            data = left ? (sext << (DATA_W - 1 - keep)) : sext;
        else
            data = left ? (zext << (DATA_W - keep)) : zext;
    end
endmodule

// File: rtl/adcfmt_regular.sv
// Module: adcfmt_regular
// Holds the single shared regular data register, the unread bit and the
// overrun flag. In DMA mode an overrun drops the new result and holds the
// sequence aborted until the flag is cleared.
// Assumes rd marks a read of the register in the same cycle.
module adcfmt_regular #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd,
    input  logic              clr,
    input  logic              dma_en,
    output logic [DATA_W-1:0] data,
    output logic              unread,
    output logic              ovr,
    output logic              dma_req,
    output logic              abort
);
    logic blocked, wr_ok, ovr_evt, take;

    // Decide whether this cycle's result is accepted and whether it overruns.
    always_comb begin
        blocked = ovr && dma_en;
        wr_ok   = wr_req && !blocked;
        ovr_evt = wr_ok && unread && !rd;
        take    = wr_ok && !(ovr_evt && dma_en);
    end

    // Update the data, the unread bit and the overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data   <= '0;
            unread <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (take) data <= wr_data;
            if (take)
                unread <= 1'b1;
            else if (rd)
                unread <= 1'b0;
            if (ovr_evt)
                ovr <= 1'b1;
            else if (clr)
                ovr <= 1'b0;
        end
    end

    assign dma_req = unread && dma_en && !ovr;
    assign abort   = ovr && dma_en;

    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(wr_req && unread && !rd));

    // R8
    unread_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr_req) |=> !unread);

    // R10
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && dma_en) |=> $stable(data));

    // R11
    ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_req) |=> !ovr);
endmodule

// File: rtl/adcfmt_inject.sv
// Module: adcfmt_inject
// The bank of injected data slots. The rank of an injected result selects
// the slot it is written to.
// Assumes slot is below SLOTS whenever wr_req is set.
module adcfmt_inject #(
    parameter int DATA_W = 16,
    parameter int SLOTS  = 4,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_req,
    input  logic [IDX_W-1:0]        slot,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [SLOTS*DATA_W-1:0] data
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic hit;
        assign hit = wr_req && (slot == IDX_W'(k));

        // Load this slot when an injected result with its rank arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data[k*DATA_W +: DATA_W] <= '0;
            else if (hit)
                data[k*DATA_W +: DATA_W] <= wr_data;
        end

        // R7
        slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_req && slot == IDX_W'(k)) |=> $stable(data[k*DATA_W +: DATA_W]));
    end
endmodule

// File: rtl/adc_result_formatter.sv
// Module: adc_result_formatter (top)
// Routes each tagged conversion through one shared shaping path to either
// the regular register or an injected slot, and reports the conversion time.
// Assumes at most one conversion result arrives per cycle.
module adc_result_formatter #(
    parameter int CODE_W = 12,
    parameter int DATA_W = 16,
    parameter int SLOTS  = 4,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CYC_W = $clog2(CODE_W + 4)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cv_valid,
    input  logic [CODE_W-1:0]       cv_code,
    input  logic                    cv_inj,
    input  logic [IDX_W-1:0]        cv_rank,
    input  logic [1:0]              cfg_res,
    input  logic                    cfg_left,
    input  logic                    cfg_dma_en,
    input  logic [SLOTS-1:0]        cfg_ofs_en,
    input  logic [SLOTS*CODE_W-1:0] cfg_ofs,
    input  logic                    rd_regular,
    input  logic                    ovr_clear,
    output logic [CYC_W-1:0]        conv_cycles,
    output logic [DATA_W-1:0]       reg_data,
    output logic                    reg_unread,
    output logic [SLOTS*DATA_W-1:0] inj_data,
    output logic                    ovr_flag,
    output logic                    dma_req,
    output logic                    seq_abort
);
    logic [DATA_W-1:0] shaped;
    logic [CODE_W-1:0] slot_ofs;
    logic              use_ofs;

    assign slot_ofs    = cfg_ofs[cv_rank*CODE_W +: CODE_W];
    assign use_ofs     = cv_inj && cfg_ofs_en[cv_rank];
    assign conv_cycles = CYC_W'(CODE_W + 3) - CYC_W'({cfg_res, 1'b0});

    adcfmt_shape #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_shape (
        .code(cv_code), .res_sel(cfg_res), .left(cfg_left),
        .signed_en(use_ofs), .ofs(slot_ofs), .data(shaped)
    );

    adcfmt_regular #(.DATA_W(DATA_W)) u_regular (
        .clk(clk), .rst_n(rst_n), .wr_req(cv_valid && !cv_inj),
        .wr_data(shaped), .rd(rd_regular), .clr(ovr_clear),
        .dma_en(cfg_dma_en), .data(reg_data), .unread(reg_unread),
        .ovr(ovr_flag), .dma_req(dma_req), .abort(seq_abort)
    );

    adcfmt_inject #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_inject (
        .clk(clk), .rst_n(rst_n), .wr_req(cv_valid && cv_inj),
        .slot(cv_rank), .wr_data(shaped), .data(inj_data)
    );

    // R3
    rj_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_valid && cv_inj && cv_rank == '0 && !cfg_ofs_en[0] && !cfg_left && cfg_res == 2'd3)
        |=> inj_data[DATA_W-1:CODE_W-6] == '0);
endmodule

// File: tb/tb_adc_result_formatter.sv
module tb_adc_result_formatter;
    localparam int CW = 12;
    localparam int DW = 16;
    localparam int NS = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           cv_valid = 1'b0;
    logic [CW-1:0]  cv_code = '0;
    logic           cv_inj = 1'b0;
    logic [1:0]     cv_rank = '0;
    logic [1:0]     cfg_res = '0;
    logic           cfg_left = 1'b0;
    logic           cfg_dma_en = 1'b0;
    logic [NS-1:0]  cfg_ofs_en = '0;
    logic [NS*CW-1:0] cfg_ofs = '0;
    logic           rd_regular = 1'b0;
    logic           ovr_clear = 1'b0;
    logic [3:0]     conv_cycles;
    logic [DW-1:0]  reg_data;
    logic           reg_unread;
    logic [NS*DW-1:0] inj_data;
    logic           ovr_flag, dma_req, seq_abort;

    adc_result_formatter dut (
        .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_code(cv_code),
        .cv_inj(cv_inj), .cv_rank(cv_rank), .cfg_res(cfg_res), .cfg_left(cfg_left),
        .cfg_dma_en(cfg_dma_en), .cfg_ofs_en(cfg_ofs_en), .cfg_ofs(cfg_ofs),
        .rd_regular(rd_regular), .ovr_clear(ovr_clear), .conv_cycles(conv_cycles),
        .reg_data(reg_data), .reg_unread(reg_unread), .inj_data(inj_data),
        .ovr_flag(ovr_flag), .dma_req(dma_req), .seq_abort(seq_abort)
    );

    int n_chk = 0;
    int n_err = 0;
    int m_reg = 0;
    int m_inj [NS];
    bit m_unread = 0;
    bit m_ovr = 0;

    // Reference formatting from the requirements, in plain integer arithmetic.
    function automatic int fmt(int code, bit sgn, int ofs, int sel, bit left);
        int bits = 12 - 2 * sel;
        int red = code / (1 << (2 * sel));
        int v;
        if (sgn) begin
            v = red - (ofs % (1 << bits));
            if (left) v = v * (1 << (15 - bits));
        end else begin
            v = left ? red * (1 << (16 - bits)) : red;
        end
        return v & 32'hFFFF;
    endfunction

    task automatic model_edge();
        if (!rst_n) begin
            m_reg = 0; m_unread = 0; m_ovr = 0;
            foreach (m_inj[i]) m_inj[i] = 0;
        end else begin
            int r = int'(cv_rank);
            int ofs = int'(cfg_ofs[r*CW +: CW]);
            bit evt = 0;
            bit clr_ok = ovr_clear;
            if (cv_valid && cv_inj)
                m_inj[r] = fmt(int'(cv_code), cfg_ofs_en[r], ofs, int'(cfg_res), cfg_left);
            if (cv_valid && !cv_inj && !(m_ovr && cfg_dma_en)) begin
                evt = m_unread && !rd_regular;
                if (!(evt && cfg_dma_en)) begin
                    m_reg = fmt(int'(cv_code), 1'b0, 0, int'(cfg_res), cfg_left);
                    m_unread = 1;
                end
            end else if (rd_regular) begin
                m_unread = 0;
            end
            if (evt) m_ovr = 1;
            else if (clr_ok) m_ovr = 0;
        end
    endtask

    task automatic check(string tag);
        logic [87:0] act, exp_v;
        logic [63:0] inj_e;
        for (int i = 0; i < NS; i++) inj_e[i*16 +: 16] = m_inj[i][15:0];
        exp_v = {m_reg[15:0], m_unread, inj_e, m_ovr,
                 cfg_dma_en && m_unread && !m_ovr, m_ovr && cfg_dma_en,
                 4'(15 - 2 * int'(cfg_res))};
        act = {reg_data, reg_unread, inj_data, ovr_flag, dma_req, seq_abort, conv_cycles};
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic cyc(bit v, int code, bit inj, int rank, bit rd, bit clr, string tag);
        cv_valid = v; cv_code = CW'(code); cv_inj = inj; cv_rank = 2'(rank);
        rd_regular = rd; ovr_clear = clr;
        step(tag);
        cv_valid = 0; rd_regular = 0; ovr_clear = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog for all requirements actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        foreach (m_inj[i]) m_inj[i] = 0;
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        step("R1 after reset");

        // Resolution and alignment on the regular path, offsets enabled but unused (R6).
        cfg_ofs_en = 4'hF;
        cfg_ofs = {12'h123, 12'h456, 12'h789, 12'hABC};
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 2; l++) begin
                cfg_res = 2'(s); cfg_left = l[0];
                cyc(1, 12'hA5C, 0, 0, 0, 0, "R2 R3 R4 R6 regular");
                cyc(0, 0, 0, 0, 1, 0, "R8 read clears unread");
            end
        end

        // Injected slots, with and without offsets, negative and positive (R5, R7).
        cfg_ofs = {12'h010, 12'hFFF, 12'h800, 12'h100};
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 2; l++) begin
                cfg_res = 2'(s); cfg_left = l[0];
                cfg_ofs_en = 4'b0101;
                for (int k = 0; k < NS; k++) cyc(1, 12'h0F3 + k * 12'h311, 1, k, 0, 0, "R5 R7 injected");
            end
        end
        cfg_ofs_en = 4'b0000; cfg_res = 2'd3; cfg_left = 0;
        cyc(1, 12'hFFF, 1, 0, 0, 0, "R3 six-bit right aligned");

        // Overrun without DMA.
        cfg_res = 0; cfg_dma_en = 0;
        cyc(1, 12'h111, 0, 0, 0, 0, "R8 first regular");
        cyc(1, 12'h222, 0, 0, 0, 0, "R9 R10 overrun overwrites");
        cyc(0, 0, 0, 0, 0, 1, "R11 clear");
        cyc(1, 12'h333, 0, 0, 1, 0, "R9 read with new write");
        cyc(1, 12'h444, 0, 0, 0, 1, "R11 set wins over clear");
        cyc(0, 0, 0, 0, 1, 1, "R11 R8 clear and read");

        // DMA mode.
        cfg_dma_en = 1;
        cyc(1, 12'h555, 0, 0, 0, 0, "R12 request");
        cyc(1, 12'h666, 0, 0, 0, 0, "R10 overrun dropped");
        cyc(1, 12'h777, 0, 0, 0, 0, "R10 aborted ignored");
        cyc(1, 12'h888, 1, 2, 0, 0, "R7 injected during abort");
        cyc(0, 0, 0, 0, 1, 0, "R12 read while aborted");
        cyc(0, 0, 0, 0, 0, 1, "R11 clear ends abort");
        cyc(1, 12'h999, 0, 0, 0, 0, "R10 R12 resumes");

        // Random phase.
        for (int n = 0; n < 3000; n++) begin
            cfg_res = 2'($urandom); cfg_left = 1'($urandom);
            cfg_dma_en = ($urandom % 4) == 0; cfg_ofs_en = 4'($urandom);
            cfg_ofs = {$urandom, $urandom}[NS*CW-1:0];
            cyc(($urandom % 3) != 0, int'($urandom % 4096), 1'($urandom), int'($urandom % 4),
                ($urandom % 3) == 0, ($urandom % 5) == 0, "random R5 R9 R10 R11 R12");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule